// File: doc/BRIEF.md
# Signed BCD Reaction Countdown Timer

This block is the counting core of a reaction game. It holds a four-digit decimal value in hundredths of a second and loads 10.00 on reset and on an init request. One start/stop pulse sets it running. While it runs, each tick enable (one pulse per 0.01 s, made elsewhere) lowers the shown value by one hundredth. When the value reaches 0.00 the count keeps going: the next tick raises a minus flag and shows -0.01, and later ticks grow the magnitude. A second start/stop pulse freezes the value so the player can see how close to zero they stopped.

Each decimal digit is its own counter that can count up or down. The digits form a ripple chain: the tick enters the lowest digit, and each digit passes a borrow (counting down) or a carry (counting up) to the next. The count direction is taken from the minus flag, and also from the zero state, so the step across zero moves 0.00 to -0.01 in a single edge. While the value is negative the magnitude stops at 9.99.

Top module: `bcd_react_timer`

## Requirements
- R1: After reset or init, digits_o shows 10.00. Nibble [3:0] holds hundredths, [7:4] tenths, [11:8] units and [15:12] tens, so the value is 16'h1000, minus_o is 0, and the timer is armed. While armed, ticks do not change the value.
- R2: Once running, each cycle with tick_i high lowers a positive value by 0.01 with decimal borrows. For example 10.00 becomes 9.99 and 9.90 becomes 9.89. Every nibble stays in the range 0 to 9.
- R3: zero_o is 1 exactly when all four digits are 0. minus_o is never 1 while zero_o is 1.
- R4: A tick while running at +0.00 gives -0.01: digits 16'h0001, with minus_o rising on that same clock edge.
- R5: While minus_o is 1, each tick raises the magnitude by 0.01 with decimal carries. For example -0.09 becomes -0.10 and -0.99 becomes -1.00.
- R6: While negative, the magnitude saturates at 9.99 (digits 16'h0999). Further ticks leave the value and the flag unchanged.
- R7: A start/stop pulse while running freezes the value. After that, ticks and further start/stop pulses have no effect until init.
- R8: init_i takes priority over tick_i and start_stop_i in the same cycle. It reloads 10.00, clears minus_o and returns the timer to the armed state, whatever state it was in.
- R9: In a cycle without tick_i the displayed value and minus_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 0.01 s step |
| start_stop_i | input | 1 | One-cycle start/stop request |
| init_i | input | 1 | One-cycle reload request |
| digits_o | output | 16 | Four BCD digits, hundredths in the low nibble |
| minus_o | output | 1 | Value is negative |
| zero_o | output | 1 | All digits are zero |

## Verification
The assertions check on every cycle that each digit stays in the range 0 to 9 and holds when no count reaches it. They also check that zero and minus are never high together, that the minus flag rises only from 0.00 onto -0.01, that the floor at -9.99 holds, that a frozen timer stays frozen, and that init reloads 10.00. Only the bench's scenarios can show the whole decimal sequence from 10.00 through zero to -9.99, tick by tick, against an arithmetic model. The same is true of the start/stop and init priority orderings seen at the ports.

// File: rtl/rct_pkg.sv
package rct_pkg;
    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;

    typedef enum logic [1:0] {
        MODE_ARMED = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_HOLD  = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  minus;
    } ctrl_state_t;
endpackage

// File: rtl/rct_digit.sv
module rct_digit
    import rct_pkg::*;
#(
    parameter bcd_t RESET_VAL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  bcd_t load_val_i,
    input  logic step_i,
    input  logic up_i,
    output logic step_o,
    output bcd_t q_o
);
    bcd_t q_d, q_q;

    always_comb begin
        q_d    = q_q;
        step_o = step_i && (up_i ? (q_q == 4'd9) : (q_q == 4'd0));
        if (load_i) begin
            q_d = load_val_i;
        end else if (step_i) begin
            if (up_i) q_d = (q_q == 4'd9) ? 4'd0 : q_q + 4'd1;
            else      q_d = (q_q == 4'd0) ? 4'd9 : q_q - 4'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= RESET_VAL;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    // R2: every digit is a legal decimal value
    a_r2_digit_bcd: assert property (@(posedge clk) disable iff (!rst_n)
        q_q <= 4'd9);

    // R9: a digit that is not stepped or loaded keeps its value
    a_r9_digit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(q_q));
endmodule

// File: rtl/rct_ctrl.sv
module rct_ctrl
    import rct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic start_stop_i,
    input  logic tick_i,
    input  logic zero_i,
    input  logic at_floor_i,
    output logic count_en_o,
    output logic count_up_o,
    output logic minus_o
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        count_en_o = !init_i && tick_i && (st_q.mode == MODE_RUN)
                     && !(st_q.minus && at_floor_i);
        count_up_o = st_q.minus || zero_i;
        if (init_i) begin
            st_d.mode  = MODE_ARMED;
            st_d.minus = 1'b0;
        end else begin
            if (count_en_o && zero_i && !st_q.minus) st_d.minus = 1'b1;
            if (start_stop_i) begin
                case (st_q.mode)
                    MODE_ARMED: st_d.mode = MODE_RUN;
                    MODE_RUN:   st_d.mode = MODE_HOLD;
                    default:    st_d.mode = MODE_HOLD;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_ARMED;
            st_q.minus <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign minus_o = st_q.minus;

    // R7: a frozen timer stays frozen until init
    a_r7_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_HOLD && !init_i) |=> (st_q.mode == MODE_HOLD));

    // R1: nothing counts while armed
    a_r1_armed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ARMED) |-> !count_en_o);

    // R8: init always returns to the armed state with a clear sign
    a_r8_init_state: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (st_q.mode == MODE_ARMED) && !st_q.minus);
endmodule

// File: rtl/bcd_react_timer.sv
module bcd_react_timer
    import rct_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int LOAD_TOP   = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic                        start_stop_i,
    input  logic                        init_i,
    output logic [NUM_DIGITS*BCD_W-1:0] digits_o,
    output logic                        minus_o,
    output logic                        zero_o
);
    localparam int DW = NUM_DIGITS * BCD_W;
    localparam logic [DW-1:0] LOAD_VEC = DW'(LOAD_TOP) << (DW - BCD_W);

    logic [NUM_DIGITS:0]   chain;
    logic [NUM_DIGITS-1:0] floor_ok;
    logic                  count_en, count_up, at_floor;

    assign chain[0] = count_en;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        localparam bcd_t DIG_INIT = (g == NUM_DIGITS - 1) ? bcd_t'(LOAD_TOP) : bcd_t'(0);
        bcd_t q;

        rct_digit #(.RESET_VAL(DIG_INIT)) i_digit (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (init_i),
            .load_val_i (DIG_INIT),
            .step_i     (chain[g]),
            .up_i       (count_up),
            .step_o     (chain[g+1]),
            .q_o        (q)
        );

        assign digits_o[g*BCD_W +: BCD_W] = q;
        if (g == NUM_DIGITS - 1) begin : g_top
            assign floor_ok[g] = (q == 4'd0);
        end else begin : g_low
            assign floor_ok[g] = (q == 4'd9);
        end
    end

    assign zero_o   = (digits_o == '0);
    assign at_floor = &floor_ok;

    rct_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init_i),
        .start_stop_i (start_stop_i),
        .tick_i       (tick_i),
        .zero_i       (zero_o),
        .at_floor_i   (at_floor),
        .count_en_o   (count_en),
        .count_up_o   (count_up),
        .minus_o      (minus_o)
    );

    // R3: zero is never negative
    a_r3_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> !minus_o);

    // R4: the sign rises only when stepping off zero onto one hundredth
    a_r4_sign_cross: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(minus_o) |-> (digits_o == DW'(1)) && $past(zero_o));

    // R6: the negative floor holds
    a_r6_floor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (minus_o && at_floor && !init_i) |=> $stable(digits_o) && minus_o);

    // R8: init reloads the start value
    a_r8_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (digits_o == LOAD_VEC) && !minus_o);
endmodule

// File: tb/test_bcd_react_timer.sv
`timescale 1ns/1ps
module test_bcd_react_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ss = 1'b0;
    logic        init = 1'b0;
    logic [15:0] digits;
    logic        minus, zero;

    int compared = 0;
    int mismatched = 0;
    int exp_val = 1000;   // signed hundredths
    int mode = 0;         // 0 armed, 1 run, 2 hold

    always #2.5 clk = ~clk;

    bcd_react_timer i_bcd_react_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_stop_i(ss),
        .init_i(init), .digits_o(digits), .minus_o(minus), .zero_o(zero)
    );

    function automatic logic [15:0] to_bcd(input int v);
        int m = (v < 0) ? -v : v;
        return {4'((m / 1000) % 10), 4'((m / 100) % 10), 4'((m / 10) % 10), 4'(m % 10)};
    endfunction

    task automatic check(input string tag);
        logic [15:0] ed = to_bcd(exp_val);
        logic em = (exp_val < 0);
        logic ez = (exp_val == 0);
        compared++;
        if (digits !== ed || minus !== em || zero !== ez) begin
            mismatched++;
            $display("FAIL %s: actual digits=%h minus=%b zero=%b expected digits=%h minus=%b zero=%b",
                     tag, digits, minus, zero, ed, em, ez);
        end
    endtask

    task automatic step(input logic s, input logic i, input logic t, input string tag);
        ss = s; init = i; tick = t;
        @(negedge clk);
        ss = 1'b0; init = 1'b0; tick = 1'b0;
        if (i) begin
            exp_val = 1000; mode = 0;
        end else begin
            if (t && mode == 1 && exp_val > -999) exp_val--;
            if (s) mode = (mode == 0) ? 1 : 2;
        end
        check(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value");
        for (int k = 0; k < 3; k++) step(0, 0, 1, "R1 armed ignores tick");
        step(1, 0, 0, "R1 start");
        // full sweep from 10.00 through zero to the floor and past it
        for (int k = 0; k < 2004; k++) begin
            string tag;
            if (exp_val > 1)        tag = "R2 count down";
            else if (exp_val == 1)  tag = "R3 reach zero";
            else if (exp_val == 0)  tag = "R4 cross zero";
            else if (exp_val > -999) tag = "R5 count up negative";
            else                    tag = "R6 floor";
            step(0, 0, 1, tag);
            if (k % 97 == 0) step(0, 0, 0, "R9 no tick hold");
        end
        step(1, 0, 0, "R7 stop");
        for (int k = 0; k < 3; k++) step(0, 0, 1, "R7 frozen ignores tick");
        step(1, 0, 1, "R7 frozen ignores start");
        step(0, 0, 1, "R7 still frozen");
        step(0, 1, 1, "R8 init beats tick");
        step(1, 0, 0, "R8 restart");
        for (int k = 0; k < 5; k++) step(0, 0, 1, "R2 short run");
        step(0, 0, 0, "R9 idle run");
        step(1, 0, 1, "R7 stop with tick");
        step(1, 1, 0, "R8 init beats start");
        step(0, 0, 1, "R8 armed after init");
        step(1, 0, 0, "R8 start again");
        for (int k = 0; k < 3; k++) step(0, 0, 1, "R2 run again");
        step(0, 1, 1, "R8 init while running");
        step(0, 0, 1, "R1 armed after init");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule